// File: doc/BRIEF.md
# Reset and Stack Sequencing Unit

This block is the part of a small 8-bit processor core that brings the register file out of reset and carries out every instruction whose work is a run of stack transfers. After reset it clears the accumulator, both index registers and the condition code register, places the stack pointer at 0x017F, and fetches the start address as a big-endian 16-bit word from 0xFFFE/0xFFFF before it will take any instruction.

Once it is idle, the front end offers it an opcode together with a flag that says whether the alternate-index prefix preceded it. The block then runs the byte sequence for that opcode on a byte-wide synchronous memory port. Each access takes one cycle, and read data returns the cycle after the address. It raises `done` when the last byte has moved. Pushes store at the stack pointer and then move it down. Pops move the stack pointer up and then read. The halt and wait-for-interrupt opcodes clear the interrupt mask and park the block in a halted state until the next reset.

Top module: `stack_sequencer`

## Requirements
- R1: While reset is asserted, regA, regX, regY and regCc are 0x00, regSp is 0x017F and halted is 0, whatever values they held before.
- R2: After reset is released, the block reads 0xFFFE and then 0xFFFF on consecutive cycles. The first byte becomes regPc[15:8] and the second becomes regPc[7:0]. busy stays high until this fetch completes.
- R3: Opcode 0x84 pops into regA, 0x86 pops into regCc, and 0x85 pops into regX, or into regY when opAlt is 1. A pop first increments regSp and then reads the byte at the new regSp.
- R4: Opcode 0x88 pushes regA, 0x8A pushes regCc, and 0x89 pushes regX, or regY when opAlt is 1. A push writes the byte at regSp with memWe high and then decrements regSp.
- R5: Opcode 0x81 pops two bytes into regPc, the first popped byte being the high byte.
- R6: Opcode 0x80 pops five bytes in this order: regCc, regA, regX, regPc high byte, regPc low byte. regSp ends 5 above its start.
- R7: Opcodes 0x8E and 0x8F clear regCc bit 3 (the interrupt mask) and leave regPc unchanged. halted then goes high and stays high until reset. While halted, offered opcodes cause no memory write, no regSp change and no done.
- R8: Every memory access takes one cycle. done is high for one cycle. For a push it is the write cycle (latency 1 after acceptance). For a sequence of n reads it is the cycle the last byte is captured (latency n+1). The new register values are visible in the following cycle.
- R9: Any other opcode completes with done one cycle after acceptance and changes no register and no memory. The opAlt flag changes only the target of 0x85 and 0x89.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Opcode offered; taken when busy is low |
| opCode | input | 8 | Opcode byte |
| opAlt | input | 1 | Alternate-index prefix seen before the opcode |
| busy | output | 1 | Sequence in progress or halted |
| done | output | 1 | Last byte of the current sequence transferred |
| halted | output | 1 | Halt or wait-for-interrupt entered |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRdata | input | 8 | Memory read data, valid the cycle after the address |
| regA | output | 8 | Accumulator |
| regX | output | 8 | Index register X |
| regY | output | 8 | Index register Y |
| regCc | output | 8 | Condition codes, bit 3 the interrupt mask |
| regSp | output | 16 | Stack pointer |
| regPc | output | 16 | Program counter |

## Verification
The sequencer is driven with pops into each single register, pops with and without the prefix, and pushes of every source. Pushes are interleaved with pops so that return and return-from-interrupt read back the stored bytes in a known order, which exposes swapped byte order or a misplaced pointer update. An unassigned opcode and a prefixed pop of A show whether the prefix leaks into targets it must not touch. Reset is applied twice, once on top of nonzero registers, and both halt opcodes are entered from a condition code value with the mask set.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  localparam logic [7:0] OP_RETI   = 8'h80;
  localparam logic [7:0] OP_RET    = 8'h81;
  localparam logic [7:0] OP_POPA   = 8'h84;
  localparam logic [7:0] OP_POPXY  = 8'h85;
  localparam logic [7:0] OP_POPCC  = 8'h86;
  localparam logic [7:0] OP_PUSHA  = 8'h88;
  localparam logic [7:0] OP_PUSHXY = 8'h89;
  localparam logic [7:0] OP_PUSHCC = 8'h8A;
  localparam logic [7:0] OP_HALT   = 8'h8E;
  localparam logic [7:0] OP_WFI    = 8'h8F;

  typedef enum logic [2:0] {K_NONE, K_POP, K_PUSH, K_RET, K_RETI, K_VEC, K_HALT} opKind_e;
  typedef enum logic [2:0] {SEL_A, SEL_X, SEL_Y, SEL_CC, SEL_PCH, SEL_PCL} regSel_e;

  typedef struct packed {
    logic     memRead;
    logic     memWrite;
    logic     useVec;
    logic [2:0] vecOfs;
    logic     capEn;
    regSel_e  capSel;
    regSel_e  srcSel;
    logic     clrMask;
  } strobe_t;

  function automatic logic [2:0] seqLen(opKind_e k);
    case (k)
      K_POP:        return 3'd1;
      K_RET, K_VEC: return 3'd2;
      K_RETI:       return 3'd5;
      default:      return 3'd0;
    endcase
  endfunction

  function automatic regSel_e selAt(opKind_e k, logic [2:0] idx, regSel_e base);
    if (k == K_POP) return base;
    if (k == K_RETI) begin
      case (idx)
        3'd0:    return SEL_CC;
        3'd1:    return SEL_A;
        3'd2:    return SEL_X;
        3'd3:    return SEL_PCH;
        default: return SEL_PCL;
      endcase
    end
    return (idx == 3'd0) ? SEL_PCH : SEL_PCL;
  endfunction

endpackage

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
  import stkseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [7:0] opCode,
  input  logic       opAlt,
  output strobe_t    stb,
  output logic       done,
  output logic       busy,
  output logic       halted
);

  typedef enum logic [1:0] {S_RUN, S_IDLE, S_HALT} state_e;

  state_e     state;
  opKind_e    kind;
  regSel_e    baseSel;
  regSel_e    capSelQ;
  logic [2:0] issueIdx;
  logic       capPending;

  opKind_e    decKind;
  regSel_e    decSel;
  logic [2:0] len;
  logic       isRead;
  logic       issuing;

  always_comb begin
    decKind = K_NONE;
    decSel  = SEL_A;
    case (opCode)
      OP_RETI:   decKind = K_RETI;
      OP_RET:    decKind = K_RET;
      OP_POPA:   decKind = K_POP;
      OP_POPXY:  begin decKind = K_POP;  decSel = opAlt ? SEL_Y : SEL_X; end
      OP_POPCC:  begin decKind = K_POP;  decSel = SEL_CC; end
      OP_PUSHA:  decKind = K_PUSH;
      OP_PUSHXY: begin decKind = K_PUSH; decSel = opAlt ? SEL_Y : SEL_X; end
      OP_PUSHCC: begin decKind = K_PUSH; decSel = SEL_CC; end
      OP_HALT, OP_WFI: decKind = K_HALT;
      default:   decKind = K_NONE;
    endcase
  end

  assign len     = seqLen(kind);
  assign isRead  = (len != 3'd0);
  assign issuing = (state == S_RUN) && isRead && (issueIdx < len);

  always_comb begin
    stb.memRead  = issuing;
    stb.memWrite = (state == S_RUN) && (kind == K_PUSH);
    stb.useVec   = (kind == K_VEC);
    stb.vecOfs   = issueIdx;
    stb.capEn    = capPending;
    stb.capSel   = capSelQ;
    stb.srcSel   = baseSel;
    stb.clrMask  = (state == S_RUN) && (kind == K_HALT);
  end

  assign done   = (state == S_RUN) && (isRead ? (capPending && !issuing) : 1'b1);
  assign busy   = (state != S_IDLE);
  assign halted = (state == S_HALT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_RUN;
      kind       <= K_VEC;
      baseSel    <= SEL_A;
      capSelQ    <= SEL_PCH;
      issueIdx   <= '0;
      capPending <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (opValid) begin
          state      <= S_RUN;
          kind       <= decKind;
          baseSel    <= decSel;
          issueIdx   <= '0;
          capPending <= 1'b0;
        end
        S_RUN: begin
          capPending <= issuing;
          if (issuing) begin
            capSelQ  <= selAt(kind, issueIdx, baseSel);
            issueIdx <= issueIdx + 3'd1;
          end
          if (done) state <= (kind == K_HALT) ? S_HALT : S_IDLE;
        end
        default: state <= S_HALT;
      endcase
    end
  end

  // R7
  haltHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R8
  doneOnce_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/stkseq_dpath.sv
module stkseq_dpath
  import stkseq_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 16,
  parameter logic [AW-1:0] SP_INIT  = 16'h017F,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFE,
  parameter int          MASK_BIT = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic [DW-1:0] regA,
  output logic [DW-1:0] regX,
  output logic [DW-1:0] regY,
  output logic [DW-1:0] regCc,
  output logic [AW-1:0] regSp,
  output logic [AW-1:0] regPc
);

  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] vecOfsWide;
  assign vecOfsWide = {{(AW-3){1'b0}}, stb.vecOfs};

  always_comb begin
    if (stb.useVec)        memAddr = VEC_ADDR + vecOfsWide;
    else if (stb.memWrite) memAddr = regSp;
    else                   memAddr = regSp + ONE;
  end

  assign memWe = stb.memWrite;

  always_comb begin
    case (stb.srcSel)
      SEL_X:   memWdata = regX;
      SEL_Y:   memWdata = regY;
      SEL_CC:  memWdata = regCc;
      default: memWdata = regA;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA  <= '0;
      regX  <= '0;
      regY  <= '0;
      regCc <= '0;
      regSp <= SP_INIT;
      regPc <= '0;
    end else begin
      if (stb.memWrite)                     regSp <= regSp - ONE;
      else if (stb.memRead && !stb.useVec)  regSp <= regSp + ONE;
      if (stb.capEn) begin
        case (stb.capSel)
          SEL_A:   regA  <= memRdata;
          SEL_X:   regX  <= memRdata;
          SEL_Y:   regY  <= memRdata;
          SEL_CC:  regCc <= memRdata;
          SEL_PCH: regPc[AW-1 -: DW] <= memRdata;
          default: regPc[DW-1:0]     <= memRdata;
        endcase
      end
      if (stb.clrMask) regCc[MASK_BIT] <= 1'b0;
    end
  end

  // R4
  pushDec_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWrite |=> regSp == $past(regSp) - ONE);

  // R3
  popInc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.memRead && !stb.useVec) |=> regSp == $past(regSp) + ONE);

  // R7
  maskClr_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrMask |=> !regCc[MASK_BIT] && $stable(regPc));

endmodule

// File: rtl/stack_sequencer.sv
module stack_sequencer
  import stkseq_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          AW       = 16,
  parameter logic [AW-1:0] SP_INIT  = 16'h017F,
  parameter logic [AW-1:0] VEC_ADDR = 16'hFFFE,
  parameter int          MASK_BIT = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [7:0]    opCode,
  input  logic          opAlt,
  output logic          busy,
  output logic          done,
  output logic          halted,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] regA,
  output logic [DW-1:0] regX,
  output logic [DW-1:0] regY,
  output logic [DW-1:0] regCc,
  output logic [AW-1:0] regSp,
  output logic [AW-1:0] regPc
);

  strobe_t stb;

  stkseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opAlt(opAlt),
    .stb(stb), .done(done), .busy(busy), .halted(halted)
  );

  stkseq_dpath #(
    .DW(DW), .AW(AW), .SP_INIT(SP_INIT), .VEC_ADDR(VEC_ADDR), .MASK_BIT(MASK_BIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .regA(regA), .regX(regX), .regY(regY), .regCc(regCc),
    .regSp(regSp), .regPc(regPc)
  );

  // R7
  haltNoWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWe);

endmodule

// File: tb/stack_sequencer_bench.sv
module stack_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] VEC_HI = 8'h12;
  localparam logic [7:0] VEC_LO = 8'h34;
  localparam int NVEC = 12;
  // op[16:9], alt[8], expected latency[7:0]
  localparam logic [16:0] TAB [NVEC] = '{
    {8'h84, 1'b0, 8'd2}, {8'h85, 1'b0, 8'd2}, {8'h85, 1'b1, 8'd2}, {8'h86, 1'b0, 8'd2},
    {8'h88, 1'b0, 8'd1}, {8'h89, 1'b1, 8'd1}, {8'h8A, 1'b0, 8'd1}, {8'h89, 1'b0, 8'd1},
    {8'h81, 1'b0, 8'd3}, {8'h80, 1'b0, 8'd6}, {8'h9D, 1'b0, 8'd1}, {8'h84, 1'b1, 8'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic opAlt = 1'b0;
  logic busy, done, halted, memWe;
  logic [15:0] memAddr, regSp, regPc;
  logic [7:0] memWdata, regA, regX, regY, regCc;
  logic [7:0] memRdata;

  logic [7:0] ram    [512];
  logic [7:0] shadow [512];

  int nChecks = 0;
  int nFails  = 0;

  logic [7:0]  mA, mX, mY, mCc;
  logic [15:0] mSp, mPc;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (memWe) ram[memAddr[8:0]] <= memWdata;
    if (memAddr == 16'hFFFE)      memRdata <= VEC_HI;
    else if (memAddr == 16'hFFFF) memRdata <= VEC_LO;
    else                          memRdata <= ram[memAddr[8:0]];
  end

  stack_sequencer u_stack_sequencer (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opAlt(opAlt),
    .busy(busy), .done(done), .halted(halted),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRdata(memRdata),
    .regA(regA), .regX(regX), .regY(regY), .regCc(regCc), .regSp(regSp), .regPc(regPc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkRegs(input string req);
    chk(req, "regA", 32'(regA), 32'(mA));
    chk(req, "regX", 32'(regX), 32'(mX));
    chk(req, "regY", 32'(regY), 32'(mY));
    chk(req, "regCc", 32'(regCc), 32'(mCc));
    chk(req, "regSp", 32'(regSp), 32'(mSp));
    chk(req, "regPc", 32'(regPc), 32'(mPc));
  endtask

  function automatic logic [7:0] popByte();
    mSp = mSp + 16'd1;
    return shadow[mSp[8:0]];
  endfunction

  task automatic pushByte(input logic [7:0] v);
    shadow[mSp[8:0]] = v;
    mSp = mSp - 16'd1;
  endtask

  task automatic modelOp(input logic [7:0] op, input logic alt);
    case (op)
      8'h84: mA  = popByte();
      8'h85: if (alt) mY = popByte(); else mX = popByte();
      8'h86: mCc = popByte();
      8'h88: pushByte(mA);
      8'h89: pushByte(alt ? mY : mX);
      8'h8A: pushByte(mCc);
      8'h81: begin mPc[15:8] = popByte(); mPc[7:0] = popByte(); end
      8'h80: begin
        mCc = popByte(); mA = popByte(); mX = popByte();
        mPc[15:8] = popByte(); mPc[7:0] = popByte();
      end
      8'h8E, 8'h8F: mCc[3] = 1'b0;
      default: ;
    endcase
  endtask

  function automatic string reqOf(input logic [7:0] op);
    case (op)
      8'h84, 8'h85, 8'h86: return "R3";
      8'h88, 8'h89, 8'h8A: return "R4";
      8'h81: return "R5";
      8'h80: return "R6";
      8'h8E, 8'h8F: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic runOp(input logic [7:0] op, input logic alt, output int lat);
    @(negedge clk);
    opValid = 1'b1; opCode = op; opAlt = alt;
    @(negedge clk);
    opValid = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
  endtask

  task automatic resetAndVector();
    rstN = 1'b0;
    mA = 8'h00; mX = 8'h00; mY = 8'h00; mCc = 8'h00; mSp = 16'h017F; mPc = 16'h0000;
    repeat (2) @(negedge clk);
    chk("R1", "regA", 32'(regA), 32'h0);
    chk("R1", "regX", 32'(regX), 32'h0);
    chk("R1", "regY", 32'(regY), 32'h0);
    chk("R1", "regCc", 32'(regCc), 32'h0);
    chk("R1", "regSp", 32'(regSp), 32'h017F);
    chk("R1", "halted", 32'(halted), 32'h0);
    rstN = 1'b1;
    chk("R2", "first vector addr", 32'(memAddr), 32'hFFFE);
    chk("R2", "busy in fetch", 32'(busy), 32'h1);
    @(negedge clk);
    chk("R2", "second vector addr", 32'(memAddr), 32'hFFFF);
    chk("R8", "done early", 32'(done), 32'h0);
    @(negedge clk);
    chk("R8", "vector done", 32'(done), 32'h1);
    @(negedge clk);
    mPc = {VEC_HI, VEC_LO};
    chk("R2", "busy after fetch", 32'(busy), 32'h0);
    chkRegs("R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL R8 watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int lat;
    for (int i = 0; i < 512; i++) begin
      ram[i]    = 8'(i * 37 + 11);
      shadow[i] = 8'(i * 37 + 11);
    end

    resetAndVector();

    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] op;
      logic alt;
      op  = TAB[k][16:9];
      alt = TAB[k][8];
      runOp(op, alt, lat);
      modelOp(op, alt);
      chk("R8", "latency", 32'(lat), 32'(TAB[k][7:0]));
      chkRegs(reqOf(op));
      if (op == 8'h88 || op == 8'h89 || op == 8'h8A)
        chk("R4", "pushed byte", 32'(ram[9'(mSp + 16'd1)]), 32'(shadow[9'(mSp + 16'd1)]));
    end

    // halt from a mask-set state
    ram[9'(mSp + 16'd1)] = 8'hFF; shadow[9'(mSp + 16'd1)] = 8'hFF;
    runOp(8'h86, 1'b0, lat);
    modelOp(8'h86, 1'b0);
    chk("R3", "regCc loaded", 32'(regCc), 32'hFF);
    runOp(8'h8E, 1'b0, lat);
    modelOp(8'h8E, 1'b0);
    chk("R8", "halt latency", 32'(lat), 32'd1);
    chk("R7", "halted", 32'(halted), 32'h1);
    chkRegs("R7");
    // offered pushes while halted must do nothing
    opValid = 1'b1; opCode = 8'h88; opAlt = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk("R7", "write while halted", 32'(memWe), 32'h0);
      chk("R7", "done while halted", 32'(done), 32'h0);
    end
    opValid = 1'b0;
    chk("R7", "halted held", 32'(halted), 32'h1);
    chkRegs("R7");

    // reset over nonzero state, then wait-for-interrupt
    resetAndVector();
    ram[9'h180] = 8'h0C; shadow[9'h180] = 8'h0C;
    runOp(8'h86, 1'b0, lat);
    modelOp(8'h86, 1'b0);
    runOp(8'h8F, 1'b0, lat);
    modelOp(8'h8F, 1'b0);
    chk("R7", "wfi halted", 32'(halted), 32'h1);
    chk("R7", "wfi mask cleared", 32'(regCc), 32'h04);
    chkRegs("R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule